// File: doc/BRIEF.md
# Bus-Mapped Real-Time Clock with Seconds Alarm

This block is a real-time-clock peripheral that sits on a simple 32-bit register bus. It keeps a 32-bit count of elapsed seconds, holds a 32-bit alarm compare value, and raises one interrupt line from two sticky event flags: a once-per-second flag and an alarm-match flag. All registers live in the bus clock domain. The slow oscillator arrives as `slow_en`, a one-cycle strobe per slow-clock period that has already been synchronised to the bus clock. The seconds counter therefore changes in a single bus-clock edge and can never be read half-updated.

Register writes are guarded in two ways. The first is a write-ready bit: after each accepted write it stays low for a fixed number of slow-clock strobes, which models the transfer into the slow domain. The second, selected by a parameter, is a write lock. Software must write a key value to an unlock register before each protected write, and the unlock lapses once that write is accepted. Event flags are cleared by writing 0 to them. Writing 1 leaves them as they are, so a read-modify-write of the control register cannot lose a pending event.

Top module: `rtc_bus_alarm`

## Requirements
- R1: After reset the control register (byte offset 0x00) reads 0x0000_0080 (only write-ready set), the seconds (0x04), alarm (0x08), scratch (0x34) and unlock (0x3C) registers read 0, and `irq` is 0.
- R2: With control bit 0 set, the seconds register increments by one on every TICKS_PER_SEC-th `slow_en` strobe; with bit 0 clear it holds its value whatever the strobes do.
- R3: Each seconds increment sets control bit 6, the once-per-second flag, in the same edge.
- R4: Control bit 4, the alarm flag, becomes 1 in the cycle after the seconds register equals the alarm register while control bit 2 (alarm enable) is 1; it stays 0 on a match while bit 2 is 0.
- R5: A control write with 0 in bit 6 or bit 4 clears that flag, a 1 there leaves the flag unchanged, and an event in the same cycle wins over the clear.
- R6: `irq` is 1 exactly when (bit 6 and bit 5) or (bit 4 and bit 3) are set; bits 5 and 3 are the interrupt enables.
- R7: Control bit 7 (read-only) drops to 0 at the edge that accepts a register write and returns to 1 after XFER_TICKS further `slow_en` strobes; register writes made while it is 0 are ignored.
- R8: With write protection on, writes to the control, seconds, alarm and scratch registers are ignored unless the unlock register has been written with 0x0000_A55A. Bit 31 of the unlock register reads 1 while unlocked, and the unlock ends at the next accepted write.
- R9: The scratch register at 0x34 stores any 32-bit value written to it, and reads of unmapped offsets return 0.
- R10: A write to the seconds register loads the value and restarts the sub-second prescaler, so the next increment comes a full TICKS_PER_SEC strobes later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One-cycle strobe per slow-clock period, synchronous to `clk` |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising edge of `clk` |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
A wrong prescaler count shows up as an increment one strobe early or late, in the same edge that the strobe arrives, so the bench samples the seconds register after each strobe near the wrap. A stuck unlock or busy state is caught by a write that is ignored or that gets through; it appears on the very next read of the scratch or seconds register. Flag bugs are visible within one cycle on `irq` and on control bits 6 and 4, because the bench checks after every control write and after every increment.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int unsigned DW = 32;

   localparam logic [31:0] OFS_CTRL  = 32'h00;
   localparam logic [31:0] OFS_SEC   = 32'h04;
   localparam logic [31:0] OFS_ALARM = 32'h08;
   localparam logic [31:0] OFS_SCR   = 32'h34;
   localparam logic [31:0] OFS_UNLK  = 32'h3C;

   localparam int unsigned B_RDY  = 7;
   localparam int unsigned B_F1   = 6;
   localparam int unsigned B_IE1  = 5;
   localparam int unsigned B_FAL  = 4;
   localparam int unsigned B_IEAL = 3;
   localparam int unsigned B_ALEN = 2;
   localparam int unsigned B_RUN  = 0;
   localparam int unsigned B_UNLK = 31;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
   parameter int unsigned TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_en,
   input  logic run,
   input  logic restart,
   output logic tick
);
   generate
      if (TICKS_PER_SEC == 1) begin : g_direct
         assign tick = slow_en && run && !restart;
      end else begin : g_count
         localparam int unsigned PW = $clog2(TICKS_PER_SEC);
         localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);
         logic [PW-1:0] pre_q;
         assign tick = slow_en && run && !restart && (pre_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pre_q <= '0;
            else if (restart)          pre_q <= '0;
            else if (slow_en && run)   pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/rtc_write_gate.sv
module rtc_write_gate import rtc_pkg::*; #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned XFER_TICKS = 2,
   parameter bit          WPROT      = 1'b1,
   parameter logic [31:0] UNLOCK_KEY = 32'h0000_A55A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic              ready,
   output logic              unlocked,
   output logic              wr_acc
);
   localparam int unsigned BW = $clog2(XFER_TICKS + 1);
   localparam logic [BW-1:0] BUSY_LOAD = BW'(XFER_TICKS);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(OFS_SEC);
   localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(OFS_ALARM);
   localparam logic [ADDR_W-1:0] A_SCR   = ADDR_W'(OFS_SCR);
   localparam logic [ADDR_W-1:0] A_UNLK  = ADDR_W'(OFS_UNLK);

   logic [BW-1:0] busy_q;
   logic          target;

   assign target = (addr == A_CTRL) || (addr == A_SEC) || (addr == A_ALARM) || (addr == A_SCR);
   assign ready  = (busy_q == '0);
   assign wr_acc = we && target && ready && unlocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    busy_q <= '0;
      else if (wr_acc)               busy_q <= BUSY_LOAD;
      else if (slow_en && !ready)    busy_q <= busy_q - 1'b1;
   end

   generate
      if (WPROT) begin : g_lock
         logic key_hit;
         logic unl_q;
         assign key_hit  = we && (addr == A_UNLK) && (wdata == UNLOCK_KEY);
         assign unlocked = unl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       unl_q <= 1'b0;
            else if (key_hit) unl_q <= 1'b1;
            else if (wr_acc)  unl_q <= 1'b0;
         end
      end else begin : g_open
         assign unlocked = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/rtc_bus_alarm.sv
module rtc_bus_alarm import rtc_pkg::*; #(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned XFER_TICKS    = 2,
   parameter bit          WPROT         = 1'b1,
   parameter logic [31:0] UNLOCK_KEY    = 32'h0000_A55A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(OFS_SEC);
   localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(OFS_ALARM);
   localparam logic [ADDR_W-1:0] A_SCR   = ADDR_W'(OFS_SCR);
   localparam logic [ADDR_W-1:0] A_UNLK  = ADDR_W'(OFS_UNLK);

   generate
      if (ADDR_W < 6)         begin : g_bad_aw   $error("ADDR_W must reach offset 0x3C"); end
      if (XFER_TICKS < 1)     begin : g_bad_xf   $error("XFER_TICKS must be at least 1"); end
      if (TICKS_PER_SEC < 1)  begin : g_bad_tps  $error("TICKS_PER_SEC must be at least 1"); end
   endgenerate

   logic          wr_ready, unlocked, wr_acc, sec_tick;
   logic [DW-1:0] sec_q, alarm_q, scr_q;
   logic          run_q, alen_q, ie1_q, ieal_q, f1_q, fal_q;
   logic          wr_ctrl, wr_sec, alarm_hit;

   rtc_write_gate #(
      .ADDR_W(ADDR_W), .XFER_TICKS(XFER_TICKS), .WPROT(WPROT), .UNLOCK_KEY(UNLOCK_KEY)
   ) u_gate (
      .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .ready(wr_ready), .unlocked(unlocked), .wr_acc(wr_acc)
   );

   assign wr_ctrl = wr_acc && (bus_addr == A_CTRL);
   assign wr_sec  = wr_acc && (bus_addr == A_SEC);

   rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
      .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .run(run_q),
      .restart(wr_sec), .tick(sec_tick)
   );

   assign alarm_hit = alen_q && (sec_q == alarm_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q   <= '0;
         alarm_q <= '0;
         scr_q   <= '0;
      end else begin
         if (wr_sec)        sec_q <= bus_wdata;
         else if (sec_tick) sec_q <= sec_q + 1'b1;
         if (wr_acc && (bus_addr == A_ALARM)) alarm_q <= bus_wdata;
         if (wr_acc && (bus_addr == A_SCR))   scr_q   <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         alen_q <= 1'b0;
         ie1_q  <= 1'b0;
         ieal_q <= 1'b0;
         f1_q   <= 1'b0;
         fal_q  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            run_q  <= bus_wdata[B_RUN];
            alen_q <= bus_wdata[B_ALEN];
            ie1_q  <= bus_wdata[B_IE1];
            ieal_q <= bus_wdata[B_IEAL];
         end
         f1_q  <= (wr_ctrl ? (f1_q  & bus_wdata[B_F1])  : f1_q)  | sec_tick;
         fal_q <= (wr_ctrl ? (fal_q & bus_wdata[B_FAL]) : fal_q) | alarm_hit;
      end
   end

   assign irq = (f1_q && ie1_q) || (fal_q && ieal_q);

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL: begin
            bus_rdata[B_RDY]  = wr_ready;
            bus_rdata[B_F1]   = f1_q;
            bus_rdata[B_IE1]  = ie1_q;
            bus_rdata[B_FAL]  = fal_q;
            bus_rdata[B_IEAL] = ieal_q;
            bus_rdata[B_ALEN] = alen_q;
            bus_rdata[B_RUN]  = run_q;
         end
         A_SEC:   bus_rdata = sec_q;
         A_ALARM: bus_rdata = alarm_q;
         A_SCR:   bus_rdata = scr_q;
         A_UNLK:  bus_rdata[B_UNLK] = WPROT ? unlocked : 1'b1;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rtc_bus_alarm_chk.sv
module rtc_bus_alarm_chk import rtc_pkg::*; #(
   parameter int unsigned ADDR_W = 8,
   parameter bit          WPROT  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DW-1:0]     bus_wdata,
   input logic              irq,
   input logic              wr_acc,
   input logic              wr_ready,
   input logic              unlocked,
   input logic              sec_tick,
   input logic [DW-1:0]     sec_q,
   input logic [DW-1:0]     alarm_q,
   input logic [DW-1:0]     scr_q,
   input logic              alen_q,
   input logic              f1_q,
   input logic              fal_q
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(OFS_SEC);
   localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'(OFS_SCR);

   p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !(wr_acc && bus_addr == A_SEC)) |=> $stable(sec_q));
   p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> (sec_q == $past(sec_q) + 32'd1));
   p_tick_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> f1_q);
   p_alarm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (alen_q && sec_q == alarm_q) |=> fal_q);
   p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && bus_addr == A_CTRL && !bus_wdata[B_F1] && !sec_tick) |=> !f1_q);
   p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (f1_q || fal_q));
   p_busy_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> !wr_ready);
   p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !wr_ready && bus_addr == A_SCR) |=> $stable(scr_q));
   p_locked_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !unlocked && bus_addr == A_SCR) |=> $stable(scr_q));

   generate
      if (WPROT) begin : g_lock_chk
         p_unlock_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
            wr_acc |=> !unlocked);
      end
   endgenerate
endmodule

bind rtc_bus_alarm rtc_bus_alarm_chk #(.ADDR_W(ADDR_W), .WPROT(WPROT)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .irq(irq), .wr_acc(wr_acc), .wr_ready(wr_ready), .unlocked(unlocked),
   .sec_tick(sec_tick), .sec_q(sec_q), .alarm_q(alarm_q), .scr_q(scr_q),
   .alen_q(alen_q), .f1_q(f1_q), .fal_q(fal_q)
);

// File: tb/tb_rtc_bus_alarm.sv
module tb_rtc_bus_alarm;
   localparam int unsigned AW  = 8;
   localparam int unsigned TPS = 4;
   localparam int unsigned XT  = 2;
   localparam logic [31:0] KEY = 32'h0000_A55A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slow_en = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   rtc_bus_alarm #(
      .ADDR_W(AW), .TICKS_PER_SEC(TPS), .XFER_TICKS(XT), .WPROT(1'b1), .UNLOCK_KEY(KEY)
   ) dut (
      .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic unlock_wr(input logic [AW-1:0] a, input logic [31:0] d);
      wr(8'h3C, KEY);
      wr(a, d);
   endtask

   task automatic slow(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         slow_en = 1'b1;
         @(negedge clk);
         slow_en = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      n_chk++;
      if (bus_rdata !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%02h actual=%08h expected=%08h", req, a, bus_rdata, exp);
      end
   endtask

   task automatic chk_irq(input string req, input logic exp);
      #1;
      n_chk++;
      if (irq !== exp) begin
         n_bad++;
         $display("FAIL %s irq actual=%0b expected=%0b", req, irq, exp);
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", 8'h00, 32'h0000_0080);
      chk("R1", 8'h04, 32'h0);
      chk("R1", 8'h08, 32'h0);
      chk("R1", 8'h34, 32'h0);
      chk("R1", 8'h3C, 32'h0);
      chk_irq("R1", 1'b0);

      // R8 locked write ignored
      wr(8'h34, 32'h0000_1234);
      chk("R8", 8'h34, 32'h0);
      chk("R8", 8'h00, 32'h0000_0080);

      // R8 unlock, R9 scratch, R7 busy
      wr(8'h3C, KEY);
      chk("R8", 8'h3C, 32'h8000_0000);
      wr(8'h34, 32'hDEAD_BEEF);
      chk("R9", 8'h34, 32'hDEAD_BEEF);
      chk("R7", 8'h00, 32'h0000_0000);
      chk("R8", 8'h3C, 32'h0);

      // R7 writes while busy ignored, unlock survives an ignored write
      wr(8'h3C, KEY);
      wr(8'h34, 32'h0000_0001);
      chk("R7", 8'h34, 32'hDEAD_BEEF);
      chk("R8", 8'h3C, 32'h8000_0000);
      slow(1);
      chk("R7", 8'h00, 32'h0000_0000);
      slow(1);
      chk("R7", 8'h00, 32'h0000_0080);

      // R9 sweep of scratch patterns
      for (int i = 0; i < 11; i++) begin
         logic [31:0] pat;
         pat = 32'hA5A5_0000 ^ (32'h1 << (i * 3)) ^ i;
         unlock_wr(8'h34, pat);
         chk("R9", 8'h34, pat);
         slow(XT);
      end
      // R2 counter disabled holds
      chk("R2", 8'h04, 32'h0);

      unlock_wr(8'h04, 32'd10); slow(2);
      unlock_wr(8'h08, 32'd12); slow(2);
      chk("R10", 8'h04, 32'd10);
      chk("R4", 8'h08, 32'd12);

      // enable counter, both irq enables, alarm enable; flag bits written 1
      unlock_wr(8'h00, 32'h7D);
      chk("R5", 8'h00, 32'h2D);
      slow(3);
      chk("R2", 8'h04, 32'd10);
      slow(1);
      chk("R2", 8'h04, 32'd11);
      chk("R3", 8'h00, 32'hED);
      chk_irq("R6", 1'b1);

      // clear 1 Hz flag
      unlock_wr(8'h00, 32'h3D);
      chk("R5", 8'h00, 32'h2D);
      chk_irq("R6", 1'b0);
      slow(4);
      chk("R2", 8'h04, 32'd12);
      chk("R4", 8'h00, 32'hFD);
      chk_irq("R6", 1'b1);

      // writing 1 keeps flags
      unlock_wr(8'h00, 32'h7D);
      chk("R5", 8'h00, 32'h7D);
      slow(2);
      // interrupt enables off, flags still set
      unlock_wr(8'h00, 32'h55);
      chk("R6", 8'h00, 32'h55);
      chk_irq("R6", 1'b0);
      slow(2);
      chk("R2", 8'h04, 32'd13);
      chk("R4", 8'h00, 32'hD5);

      // clear both flags
      unlock_wr(8'h00, 32'h05);
      chk("R5", 8'h00, 32'h05);
      chk_irq("R5", 1'b0);
      slow(2);

      // alarm disabled, match must not set flag
      unlock_wr(8'h00, 32'h01);
      slow(2);
      unlock_wr(8'h08, 32'd15);
      slow(4);
      chk("R4", 8'h04, 32'd15);
      chk("R4", 8'h00, 32'hC1);
      chk_irq("R6", 1'b0);

      // R10 seconds write restarts prescaler
      slow(1);
      unlock_wr(8'h04, 32'd100);
      slow(3);
      chk("R10", 8'h04, 32'd100);
      slow(1);
      chk("R10", 8'h04, 32'd101);

      // R9 unmapped read
      chk("R9", 8'h10, 32'h0);
      chk("R9", 8'h08, 32'd15);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule